// File: doc/BRIEF.md
# GPIO Interrupt Detector with Banked Status and Enable

This block watches the synchronized input level of every pin of a GPIO controller and turns a configured trigger condition into a sticky status bit. Each pin supplies two configuration bits from the neighbouring configuration block: a trigger-select bit, which picks edge or level, and an invert bit, which picks the polarity. A pin is only watched while its input sensing is enabled and its use select says general-purpose I/O.

Status bits are grouped into 32-bit words, and each word is paired with an enable word of the same layout. A pin is pending when both its status bit and its enable bit are 1. One registered interrupt output reports whether any pin is pending. Software reads both kinds of word through a small register port. It clears status bits by writing ones to them. If a new event arrives in the same cycle as a clear, the event wins.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every status word and every enable word reads 0 and `irq_out` is 0.
- R2: With trigger select 0 and invert 0, a low-to-high change of a pin sets its status bit at the next clock edge. A high-to-low change sets nothing, and a steady high does not set the bit again after a clear.
- R3: With trigger select 0 and invert 1, a high-to-low change sets the status bit at the next clock edge. A low-to-high change sets nothing, and a steady low does not set the bit again after a clear.
- R4: With trigger select 1 and invert 0, the status bit is set on every clock edge while the pin is low, so it reads 1 again right after a clear for as long as the pin stays low.
- R5: With trigger select 1 and invert 1, the status bit is set on every clock edge while the pin is high, so it reads 1 again right after a clear for as long as the pin stays high.
- R6: A pin whose input-sense enable is 0, or whose use select is 0 (native function), never sets its status bit.
- R7: A register write to a status word clears each bit written as 1 and leaves bits written as 0 unchanged. Writing 0xFFFFFFFF clears the whole word. Status bits only ever become 1 through a detected event.
- R8: When an event for a pin and a clearing write to its status bit fall on the same clock edge, the bit ends up 1.
- R9: Enable words are written and read back directly. `irq_out` is 1 exactly one cycle after some pin has both status and enable set. Writing 0 to an enable word drops `irq_out` one cycle later and leaves the status bits untouched.
- R10: Pin p maps to bit p mod 32 of word p/32. Status word w is at byte address 0x80+4w and enable word w is at 0x90+4w. Bits of the last word above the pin count always read 0, including after writes of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | NUM_PINS | Synchronized input level per pin |
| trig_sel | input | NUM_PINS | Per-pin trigger select: 0 edge, 1 level |
| trig_inv | input | NUM_PINS | Per-pin invert: 0 rising/low, 1 falling/high |
| sense_en | input | NUM_PINS | Per-pin input-sense enable |
| gpio_mode | input | NUM_PINS | Per-pin use select: 1 general-purpose, 0 native |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_out | output | 1 | Registered OR of all pending bits |

## Verification
A corrupted previous-level register shows up as a phantom or missing status bit one clock after the bad value. The sweep exposes it because it reads the status word right after every level change, in all four trigger modes, at pins on each word boundary. A wrong clear/event priority shows up at the very next read in the same-cycle collision case and in the level modes. A pending bit that is kept wrong reaches `irq_out` exactly one cycle later, and the bench samples both that cycle and the one before it. A bad word decode or a leaking pad bit shows up when words are read back after all pins fire at once and after all-ones enable writes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] STAT_BASE = 8'h80;
    localparam logic [ADDR_W-1:0] EN_BASE   = 8'h90;

    // {trigger select, invert}
    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } sample_t;

    function automatic logic trig_hit(trig_e mode, sample_t s);
        case (mode)
            TRIG_RISE: return s.cur & ~s.prev;
            TRIG_FALL: return ~s.cur & s.prev;
            TRIG_LOW:  return ~s.cur;
            default:   return s.cur;
        endcase
    endfunction

    function automatic int words_for(int pins);
        return (pins + WORD_W - 1) / WORD_W;
    endfunction

    function automatic logic [WORD_W-1:0] valid_mask(int bits);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) m[i] = (i < bits);
        return m;
    endfunction

endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 94
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] trig_sel,
    input  logic [NUM_PINS-1:0] trig_inv,
    input  logic [NUM_PINS-1:0] sense_en,
    input  logic [NUM_PINS-1:0] gpio_mode,
    output logic [NUM_PINS-1:0] evt
);

    logic [NUM_PINS-1:0] prev_q;

    // Previous level follows the pin regardless of sensing, so that
    // re-enabling a pin never produces a stale edge.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= pin_level;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        trig_e   mode;
        sample_t smp;
        assign mode   = trig_e'({trig_sel[p], trig_inv[p]});
        assign smp    = {pin_level[p], prev_q[p]};
        assign evt[p] = sense_en[p] & gpio_mode[p] & trig_hit(mode, smp);
    end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int VALID_BITS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] evt,
    input  logic              clr_wr,
    input  logic              en_wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] status_o,
    output logic [WORD_W-1:0] enable_o
);

    localparam logic [WORD_W-1:0] MASK = valid_mask(VALID_BITS);

    logic [WORD_W-1:0] status_q;
    logic [WORD_W-1:0] enable_q;
    logic [WORD_W-1:0] clr;

    assign clr = clr_wr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            // event is ORed after the clear: a same-edge event survives
            status_q <= ((status_q & ~clr) | evt) & MASK;
            if (en_wr) enable_q <= wdata & MASK;
        end
    end

    assign status_o = status_q;
    assign enable_o = enable_q;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 94
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] trig_sel,
    input  logic [NUM_PINS-1:0] trig_inv,
    input  logic [NUM_PINS-1:0] sense_en,
    input  logic [NUM_PINS-1:0] gpio_mode,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                irq_out
);

    localparam int NUM_WORDS = words_for(NUM_PINS);
    localparam int PAD_W     = NUM_WORDS * WORD_W;

    logic [NUM_PINS-1:0]  evt_all;
    logic [PAD_W-1:0]     evt_pad;
    logic [PAD_W-1:0]     status_all;
    logic [PAD_W-1:0]     enable_all;
    logic [NUM_WORDS-1:0] stat_hit;
    logic [NUM_WORDS-1:0] en_hit;
    logic                 irq_q;

    gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk       (clk),
        .rst       (rst),
        .pin_level (pin_level),
        .trig_sel  (trig_sel),
        .trig_inv  (trig_inv),
        .sense_en  (sense_en),
        .gpio_mode (gpio_mode),
        .evt       (evt_all)
    );

    assign evt_pad = PAD_W'(evt_all);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam int VB = (NUM_PINS - w * WORD_W >= WORD_W) ? WORD_W
                                                              : NUM_PINS - w * WORD_W;
        localparam logic [ADDR_W-1:0] SA = STAT_BASE + ADDR_W'(4 * w);
        localparam logic [ADDR_W-1:0] EA = EN_BASE + ADDR_W'(4 * w);

        assign stat_hit[w] = (reg_addr == SA);
        assign en_hit[w]   = (reg_addr == EA);

        gpio_irq_bank #(.VALID_BITS(VB)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt_pad[w*WORD_W +: WORD_W]),
            .clr_wr   (reg_wr & stat_hit[w]),
            .en_wr    (reg_wr & en_hit[w]),
            .wdata    (reg_wdata),
            .status_o (status_all[w*WORD_W +: WORD_W]),
            .enable_o (enable_all[w*WORD_W +: WORD_W])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (stat_hit[w]) reg_rdata = status_all[w*WORD_W +: WORD_W];
            if (en_hit[w])   reg_rdata = enable_all[w*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(status_all & enable_all);
    end

    assign irq_out = irq_q;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 94
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] evt,
    input logic [NUM_PINS-1:0] status,
    input logic [NUM_PINS-1:0] enable,
    input logic [NUM_PINS-1:0] sense_en,
    input logic [NUM_PINS-1:0] gpio_mode,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [WORD_W-1:0]   reg_rdata,
    input logic                irq_out
);

    localparam int NUM_WORDS = words_for(NUM_PINS);
    localparam int LAST_BITS = NUM_PINS - (NUM_WORDS - 1) * WORD_W;
    localparam logic [WORD_W-1:0] LAST_MASK = valid_mask(LAST_BITS);
    localparam logic [ADDR_W-1:0] LAST_SA = STAT_BASE + ADDR_W'(4 * (NUM_WORDS - 1));

    // R9
    irq_follows_pending_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == $past(|(status & enable))));

    // R8
    event_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((status & $past(evt)) == $past(evt)));

    // R7
    status_only_from_event_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(status) & ~$past(evt)) == '0));

    // R6
    inactive_pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((evt & ~(sense_en & gpio_mode)) == '0));

    // R10
    pad_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == LAST_SA) |-> ((reg_rdata & ~LAST_MASK) == '0));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt_all),
    .status    (status_all[NUM_PINS-1:0]),
    .enable    (enable_all[NUM_PINS-1:0]),
    .sense_en  (sense_en),
    .gpio_mode (gpio_mode),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
);

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;

    localparam int N = 94;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  pin_level = '0;
    logic [N-1:0]  trig_sel = '0;
    logic [N-1:0]  trig_inv = '0;
    logic [N-1:0]  sense_en = '1;
    logic [N-1:0]  gpio_mode = '1;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    gpio_irq_ctrl #(.NUM_PINS(N)) u0 (
        .clk(clk), .rst(rst), .pin_level(pin_level), .trig_sel(trig_sel),
        .trig_inv(trig_inv), .sense_en(sense_en), .gpio_mode(gpio_mode),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        for (int w = 0; w < 3; w++) wr(8'h80 + 8'(4*w), 32'hFFFF_FFFF);
    endtask

    task automatic set_mode(input logic [1:0] m);
        trig_sel = {N{m[1]}};
        trig_inv = {N{m[0]}};
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int pins[6] = '{0, 31, 32, 63, 64, 93};
        string tags[4] = '{"R2 rise", "R3 fall", "R4 low", "R5 high"};

        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        for (int w = 0; w < 3; w++) begin
            rd(8'h80 + 8'(4*w), v); check("R1 status", v, 32'h0);
            rd(8'h90 + 8'(4*w), v); check("R1 enable", v, 32'h0);
        end
        check("R1 irq", {31'b0, irq_out}, 32'h0);

        // Sweep: every mode over word-boundary pins (R2..R5, R7, R10)
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 6; i++) begin
                int p = pins[i];
                logic [7:0]  sa = 8'h80 + 8'(4 * (p / 32));
                logic [31:0] b  = 32'd1 << (p % 32);
                logic [1:0]  mm = 2'(m);
                logic        idle = mm[1] ^ mm[0];
                set_mode(mm);
                pin_level = {N{idle}};
                step(); step();
                clear_all();
                rd(sa, v); check({tags[m], " idle R7"}, v, 32'h0);
                pin_level[p] = ~idle;
                step();
                rd(sa, v); check({tags[m], " trigger R10"}, v, b);
                wr(sa, b);
                rd(sa, v); check({tags[m], " after clear R7"}, v, mm[1] ? b : 32'h0);
                pin_level[p] = idle;
                step();
                rd(sa, v); check({tags[m], " back to idle"}, v, mm[1] ? b : 32'h0);
                clear_all();
                rd(sa, v); check({tags[m], " clear all R7"}, v, 32'h0);
            end
        end

        // R6 inactive pins (pin 40, word 1 bit 8), rising mode
        set_mode(2'b00);
        pin_level = '0;
        step(); step();
        clear_all();
        sense_en[40] = 1'b0;
        pin_level[40] = 1'b1;
        step();
        rd(8'h84, v); check("R6 sense off", v, 32'h0);
        pin_level[40] = 1'b0;
        step();
        sense_en = '1;
        gpio_mode[40] = 1'b0;
        pin_level[40] = 1'b1;
        step();
        rd(8'h84, v); check("R6 native", v, 32'h0);
        pin_level[40] = 1'b0;
        step();
        gpio_mode = '1;
        step();

        // R8 edge and clear on the same edge
        pin_level[40] = 1'b1;
        wr(8'h84, 32'h0000_0100);
        rd(8'h84, v); check("R8 event wins", v, 32'h0000_0100);
        pin_level[40] = 1'b0;
        step();
        clear_all();

        // R9 enable and registered irq
        wr(8'h94, 32'h0000_0100);
        rd(8'h94, v); check("R9 enable readback", v, 32'h0000_0100);
        check("R9 irq idle", {31'b0, irq_out}, 32'h0);
        pin_level[40] = 1'b1;
        step();
        check("R9 irq not yet", {31'b0, irq_out}, 32'h0);
        step();
        check("R9 irq raised", {31'b0, irq_out}, 32'h1);
        wr(8'h94, 32'h0);
        check("R9 irq one more cycle", {31'b0, irq_out}, 32'h1);
        step();
        check("R9 irq dropped", {31'b0, irq_out}, 32'h0);
        rd(8'h84, v); check("R9 status kept", v, 32'h0000_0100);
        wr(8'h94, 32'h0000_0200);
        step(); step();
        check("R9 other pin masked", {31'b0, irq_out}, 32'h0);
        wr(8'h94, 32'h0);
        clear_all();

        // R10 all pins level-high: word layout and pad bits
        set_mode(2'b11);
        pin_level = '1;
        step();
        rd(8'h80, v); check("R10 word0", v, 32'hFFFF_FFFF);
        rd(8'h84, v); check("R10 word1", v, 32'hFFFF_FFFF);
        rd(8'h88, v); check("R10 word2 pad", v, 32'h3FFF_FFFF);
        wr(8'h98, 32'hFFFF_FFFF);
        rd(8'h98, v); check("R10 enable pad", v, 32'h3FFF_FFFF);
        rd(8'h90, v); check("R10 enable word0 untouched", v, 32'h0);
        step();
        check("R9 irq from word2", {31'b0, irq_out}, 32'h1);
        pin_level = '0;
        wr(8'h98, 32'h0);
        clear_all();
        step();
        check("R9 irq cleared", {31'b0, irq_out}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule